// File: doc/BRIEF.md
# Incremental Internet Checksum Updater

This block sits in a 16-bit-per-beat header stream and rewrites one header field, either a single 16-bit word or a 32-bit value spread over two adjacent words. It does this as the packet flows past. After the rewrite, the stored header checksum would no longer be correct. The block corrects it incrementally, using ones'-complement arithmetic on the old checksum, the old field words and the new field words. It never re-sums the whole header. The field position, the new value, the checksum position and a flag saying whether the frame carries IP are taken at the first beat of each packet.

Every beat passes through a fixed delay line of `DEPTH` cycles. The checksum word can arrive before the field it depends on; while it is still inside the line, the field's contribution is folded into it. When the field comes first, its contribution is held in a per-packet pending sum that is added as the checksum word enters. Frames flagged as non-IP leave the block exactly as they arrived.

Top module: `ckup_patcher`

## Requirements
- R1: Every input beat reappears on `out_valid`/`out_sop`/`out_data` exactly `DEPTH` clock cycles after it is accepted, including beats separated by idle cycles. In a cycle where `out_valid` is 0, `out_data` is 0x0000 and `out_sop` is 0.
- R2: Words at positions that are neither a field word nor the checksum word leave unchanged.
- R3: Word positions count valid beats from 0 at the beat with `in_sop`=1. In narrow mode (`cfg_field_wide`=0), the word at `cfg_field_off` is replaced by `cfg_new_value[15:0]`. In wide mode, the word at `cfg_field_off` is replaced by `cfg_new_value[31:16]` and the word at `cfg_field_off`+1 by `cfg_new_value[15:0]`.
- R4: The word at `cfg_csum_off` is replaced by the complement of the ones'-complement sum of: the complement of the old checksum, plus, for each field word, the complement of the old word and the new word. The sum uses end-around carry, folded until it fits in 16 bits.
- R5: The result of R4 is the same whether the field lies before or after the checksum word. This holds provided every field word is accepted no more than `DEPTH`-1 cycles after the checksum word.
- R6: The folded sum is 0x0000 only when every term is 0x0000. Otherwise it lies in 0x0001..0xFFFF. So +0 and -0 give distinct results: an old checksum of 0xFFFF with an unchanged field yields 0x0000, and an all-zero-term sum yields 0xFFFF.
- R7: A packet whose first beat has `cfg_is_ip`=0 leaves the block bit-for-bit unchanged. This holds even when the word at the checksum position is 0x0000 or 0xFFFF.
- R8: All `cfg_*` inputs are sampled only on the beat with `in_sop`=1; changing them later in the packet has no effect.
- R9: A new start of packet restarts word counting and the pending sum. A checksum word of an earlier packet still in the delay line is not altered by field words of a later packet, including a field at position 0.
- R10: While `rst_n` is low, `out_valid`, `out_sop` and `out_data` are all 0.
- R11: Byte-swapping every input word, the old checksum and both halves of the new value yields the byte-swapped output of the unswapped packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_sop | input | 1 | Beat is the first word of a packet |
| in_data | input | 16 | Input header word |
| cfg_is_ip | input | 1 | Packet carries IP; 0 means pass through untouched |
| cfg_field_off | input | OFF_W | Word position of the field (upper word in wide mode) |
| cfg_field_wide | input | 1 | 1 selects a 32-bit field over two words |
| cfg_new_value | input | 32 | Replacement value; low half used in narrow mode |
| cfg_csum_off | input | OFF_W | Word position of the checksum |
| out_valid | output | 1 | Output beat present |
| out_sop | output | 1 | Output beat is the first word of a packet |
| out_data | output | 16 | Output header word, patched where required |

## Verification
Two functions can land in the same cycle. The first is the start of a new packet whose field sits at position 0. The second is the folding of a field contribution into a checksum word of the previous packet that is still inside the delay line. The bench provokes this by sending a short packet with its checksum in its last word, followed with no gap by a packet whose field is its first word. It judges the result by comparing the first packet's emitted checksum against a behavioural model that only ever adds that packet's own field words. A second overlap, a field word arriving while the checksum word sits mid-line, is provoked with idle beats spread through a packet whose checksum comes first.

// File: rtl/ckup_pkg.sv
package ckup_pkg;

    localparam int WORD_W = 16;
    localparam int VAL_W  = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    // one position of the delay line
    typedef struct packed {
        logic  valid;
        logic  sop;
        logic  csum;   // holds a running sum, emitted complemented
        logic  open;   // belongs to the packet currently entering
        word_t data;
    } slot_t;

    // ones'-complement addition, end-around carry folded until none is left
    function automatic word_t oc_add(input word_t a, input word_t b);
        logic [WORD_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        for (int k = 0; k < 2; k++) begin
            s = {1'b0, s[WORD_W-1:0]} + {{WORD_W{1'b0}}, s[WORD_W]};
        end
        return s[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/ckup_locator.sv
module ckup_locator
    import ckup_pkg::*;
#(
    parameter int OFF_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sop,
    input  logic                 cfg_is_ip,
    input  logic [OFF_W-1:0]     cfg_field_off,
    input  logic                 cfg_field_wide,
    input  logic [VAL_W-1:0]     cfg_new_value,
    input  logic [OFF_W-1:0]     cfg_csum_off,
    output logic                 hit_hi,
    output logic                 hit_lo,
    output logic                 hit_csum,
    output word_t                new_word
);

    localparam int IDX_W = OFF_W + 1;

    typedef struct packed {
        logic [IDX_W-1:0] idx;   // top bit set: past every addressable word
        logic             ip;
        logic [OFF_W-1:0] foff;
        logic             wide;
        logic [VAL_W-1:0] nv;
        logic [OFF_W-1:0] coff;
    } ctx_t;

    ctx_t ctx_q, ctx_d, cur;
    logic [IDX_W-1:0] pos_hi, pos_lo, pos_cs;

    always_comb begin
        cur = ctx_q;
        if (in_valid && in_sop) begin
            cur.idx  = '0;
            cur.ip   = cfg_is_ip;
            cur.foff = cfg_field_off;
            cur.wide = cfg_field_wide;
            cur.nv   = cfg_new_value;
            cur.coff = cfg_csum_off;
        end

        pos_hi = {1'b0, cur.foff};
        pos_lo = cur.wide ? pos_hi + IDX_W'(1) : pos_hi;
        pos_cs = {1'b0, cur.coff};

        hit_hi   = in_valid && cur.ip && cur.wide && (cur.idx == pos_hi);
        hit_lo   = in_valid && cur.ip && (cur.idx == pos_lo);
        hit_csum = in_valid && cur.ip && (cur.idx == pos_cs);
        new_word = hit_hi ? cur.nv[VAL_W-1:WORD_W] : cur.nv[WORD_W-1:0];

        ctx_d = ctx_q;
        if (in_valid) begin
            ctx_d = cur;
            if (!cur.idx[IDX_W-1]) begin
                ctx_d.idx = cur.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // a beat is at most one of: upper field word, lower field word, checksum
    AST_SINGLE_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hit_hi, hit_lo, hit_csum}) <= 1); // R3

endmodule

// File: rtl/ckup_accum.sv
module ckup_accum
    import ckup_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  logic  in_sop,
    input  word_t in_data,
    input  logic  hit_field,
    input  logic  hit_csum,
    input  word_t new_word,
    output logic  add_en,
    output word_t add_val,
    output word_t csum_seed
);

    typedef struct packed {
        word_t pend;   // contribution of field words seen before the checksum
    } acc_t;

    acc_t  acc_q, acc_d;
    word_t base;
    word_t delta;

    always_comb begin
        base      = (in_valid && in_sop) ? '0 : acc_q.pend;
        delta     = oc_add(~in_data, new_word);
        csum_seed = oc_add(~in_data, base);
        add_en    = hit_field;
        add_val   = delta;

        acc_d      = acc_q;
        acc_d.pend = base;
        if (hit_field) begin
            acc_d.pend = oc_add(base, delta);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    // a sum with any nonzero term never collapses to +0
    AST_NO_FALSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_csum && ((~in_data) != '0)) |-> (csum_seed != '0)); // R6

    // pending contribution is restarted at every packet start
    AST_PEND_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sop && !hit_field) |=> (acc_q.pend == '0)); // R9

endmodule

// File: rtl/ckup_slots.sv
module ckup_slots
    import ckup_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t entry,
    input  logic  add_en,
    input  word_t add_val,
    input  logic  new_pkt,
    output slot_t tail
);

    slot_t            q [DEPTH];
    slot_t            d [DEPTH];
    logic [DEPTH-1:0] open_csum;

    always_comb begin
        d[0] = entry;
        for (int i = 1; i < DEPTH; i++) begin
            d[i] = q[i-1];
            // a new packet's field word never belongs to an older checksum
            if (add_en && !new_pkt && q[i-1].csum && q[i-1].open) begin
                d[i].data = oc_add(q[i-1].data, add_val);
            end
            if (new_pkt) begin
                d[i].open = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                q[i] <= d[i];
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
        assign open_csum[g] = q[g].csum && q[g].open;
    end

    assign tail = q[DEPTH-1];

    // only the packet currently entering may have a checksum open for updates
    AST_ONE_OPEN_CSUM: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(open_csum) <= 1); // R9

endmodule

// File: rtl/ckup_patcher.sv
module ckup_patcher
    import ckup_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OFF_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic [WORD_W-1:0]  in_data,
    input  logic               cfg_is_ip,
    input  logic [OFF_W-1:0]   cfg_field_off,
    input  logic               cfg_field_wide,
    input  logic [VAL_W-1:0]   cfg_new_value,
    input  logic [OFF_W-1:0]   cfg_csum_off,
    output logic               out_valid,
    output logic               out_sop,
    output logic [WORD_W-1:0]  out_data
);

    logic  hit_hi, hit_lo, hit_csum, hit_field;
    word_t new_word;
    logic  add_en;
    word_t add_val, csum_seed;
    slot_t entry, tail;

    ckup_locator #(.OFF_W(OFF_W)) u_loc (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_sop         (in_sop),
        .cfg_is_ip      (cfg_is_ip),
        .cfg_field_off  (cfg_field_off),
        .cfg_field_wide (cfg_field_wide),
        .cfg_new_value  (cfg_new_value),
        .cfg_csum_off   (cfg_csum_off),
        .hit_hi         (hit_hi),
        .hit_lo         (hit_lo),
        .hit_csum       (hit_csum),
        .new_word       (new_word)
    );

    assign hit_field = hit_hi || hit_lo;

    ckup_accum u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_data   (in_data),
        .hit_field (hit_field),
        .hit_csum  (hit_csum),
        .new_word  (new_word),
        .add_en    (add_en),
        .add_val   (add_val),
        .csum_seed (csum_seed)
    );

    always_comb begin
        entry       = '0;
        entry.valid = in_valid;
        entry.sop   = in_valid && in_sop;
        entry.open  = in_valid;
        entry.csum  = hit_csum;
        if (in_valid) begin
            if (hit_field) begin
                entry.data = new_word;
            end else if (hit_csum) begin
                entry.data = csum_seed;
            end else begin
                entry.data = in_data;
            end
        end
    end

    ckup_slots #(.DEPTH(DEPTH)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .entry   (entry),
        .add_en  (add_en),
        .add_val (add_val),
        .new_pkt (in_valid && in_sop),
        .tail    (tail)
    );

    assign out_valid = tail.valid;
    assign out_sop   = tail.sop;
    assign out_data  = tail.csum ? ~tail.data : tail.data;

    // idle output cycles carry no data and no packet start
    AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0 && !out_sop)); // R1

    // a checksum slot is only ever created for an IP beat that is valid
    AST_CSUM_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_csum |-> (in_valid && !hit_field)); // R7

endmodule

// File: tb/sim_ckup_patcher.sv
module sim_ckup_patcher;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int OFF_W      = 6;
    localparam int MAXW       = 32;

    typedef logic [15:0] warr_t [MAXW];
    typedef struct {
        logic        v;
        logic        s;
        logic [15:0] d;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_sop = 1'b0;
    logic [15:0]       in_data = '0;
    logic              cfg_is_ip = 1'b0;
    logic [OFF_W-1:0]  cfg_field_off = '0;
    logic              cfg_field_wide = 1'b0;
    logic [31:0]       cfg_new_value = '0;
    logic [OFF_W-1:0]  cfg_csum_off = '0;
    logic              out_valid, out_sop;
    logic [15:0]       out_data;

    logic [15:0] cur_exp = '0;
    string       cur_tag = "R1";
    int          n_checks = 0;
    int          n_fails = 0;
    exp_t        hist [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ckup_patcher #(.DEPTH(DEPTH), .OFF_W(OFF_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .cfg_is_ip(cfg_is_ip), .cfg_field_off(cfg_field_off),
        .cfg_field_wide(cfg_field_wide), .cfg_new_value(cfg_new_value),
        .cfg_csum_off(cfg_csum_off), .out_valid(out_valid), .out_sop(out_sop),
        .out_data(out_data)
    );

    // stream monitor: output at this cycle equals the expectation recorded DEPTH cycles ago
    always @(negedge clk) begin
        exp_t e;
        e.v = in_valid; e.s = in_valid && in_sop;
        e.d = in_valid ? cur_exp : 16'h0000; e.tag = cur_tag;
        hist.push_back(e);
        if (hist.size() > DEPTH) begin
            e = hist.pop_front();
            n_checks++;
            if (out_valid !== e.v || out_sop !== e.s || out_data !== e.d) begin
                n_fails++;
                $display("FAIL %s: got v=%0b s=%0b d=%04h expected v=%0b s=%0b d=%04h",
                         e.tag, out_valid, out_sop, out_data, e.v, e.s, e.d);
            end
        end
    end

    function automatic logic [15:0] fold(input longint t);
        if (t == 0) return 16'h0000;
        return 16'(((t - 1) % 65535) + 1);
    endfunction

    // behavioural reference for one packet
    function automatic warr_t model(input warr_t w, input bit ip, input int foff,
                                    input bit wide, input logic [31:0] nv, input int coff);
        warr_t e = w;
        longint t;
        logic [15:0] c;
        if (!ip) return e;
        c = ~w[coff];
        t = longint'(c);
        if (wide) begin
            c = ~w[foff];   t += longint'(c) + longint'(nv[31:16]);
            c = ~w[foff+1]; t += longint'(c) + longint'(nv[15:0]);
            e[foff] = nv[31:16]; e[foff+1] = nv[15:0];
        end else begin
            c = ~w[foff];   t += longint'(c) + longint'(nv[15:0]);
            e[foff] = nv[15:0];
        end
        c = fold(t);
        e[coff] = ~c;
        return e;
    endfunction

    function automatic warr_t fill(input int seed);
        warr_t w;
        for (int i = 0; i < MAXW; i++) w[i] = 16'(seed * 16'h1357 + i * 16'h0b31 + 16'h4500);
        return w;
    endfunction

    function automatic logic [15:0] bswap(input logic [15:0] x);
        return {x[7:0], x[15:8]};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0; in_sop = 1'b0; in_data = 16'hDEAD;
            cur_exp = '0; cur_tag = "R1";
        end
    endtask

    task automatic send(input warr_t w, input int len, input bit ip, input int foff,
                        input bit wide, input logic [31:0] nv, input int coff,
                        input warr_t ex, input int gap, input bit scramble, input string tag);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_sop = (i == 0); in_data = w[i];
            cur_exp = ex[i]; cur_tag = tag;
            if (i == 0) begin
                cfg_is_ip = ip; cfg_field_off = OFF_W'(foff); cfg_field_wide = wide;
                cfg_new_value = nv; cfg_csum_off = OFF_W'(coff);
            end else if (scramble) begin
                cfg_is_ip = !ip; cfg_field_off = OFF_W'(i); cfg_field_wide = !wide;
                cfg_new_value = ~nv; cfg_csum_off = OFF_W'(i + 1);
            end
            if (gap > 0 && i < len - 1) idle(gap);
        end
    endtask

    task automatic pkt(input warr_t w, input int len, input bit ip, input int foff,
                       input bit wide, input logic [31:0] nv, input int coff,
                       input int gap, input bit scramble, input string tag);
        send(w, len, ip, foff, wide, nv, coff, model(w, ip, foff, wide, nv, coff),
             gap, scramble, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got run still active expected finish");
        summary();
        $finish;
    end

    initial begin
        warr_t w, ws, ex;
        logic [31:0] nv;

        // R10: outputs held at zero during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0 || out_sop !== 1'b0 || out_data !== 16'h0000) begin
                n_fails++;
                $display("FAIL R10: got v=%0b s=%0b d=%04h expected 0 0 0000",
                         out_valid, out_sop, out_data);
            end
        end
        @(posedge clk); #1; rst_n = 1'b1;
        idle(3);

        // R2 R4: narrow field after checksum
        pkt(fill(1), 12, 1, 8, 0, 32'h0000_BEEF, 5, 0, 0, "R2 R4 narrow");
        // R3: wide field across two words
        pkt(fill(2), 10, 1, 6, 1, 32'hC0A8_0101, 5, 0, 0, "R3 wide");
        idle(2);
        // R5: field ahead of checksum, narrow and wide
        pkt(fill(3), 12, 1, 1, 0, 32'h0000_1F90, 8, 0, 0, "R5 field first");
        pkt(fill(4), 12, 1, 0, 1, 32'h8001_7FFE, 9, 0, 0, "R5 wide first");
        idle(1);

        // R7: non-IP with checksum position at -0 and +0
        w = fill(5); w[5] = 16'hFFFF;
        pkt(w, 10, 0, 8, 0, 32'h0000_AAAA, 5, 0, 0, "R7 minus zero");
        w = fill(6); w[5] = 16'h0000;
        pkt(w, 10, 0, 6, 1, 32'h1234_5678, 5, 0, 0, "R7 plus zero");

        // R6: +0 / -0 corners
        w = fill(7); w[5] = 16'hFFFF; w[8] = 16'h1234;
        ex = w; ex[5] = 16'h0000;
        send(w, 10, 1, 8, 0, 32'h0000_1234, 5, ex, 0, 0, "R6 unchanged field");
        w = fill(8); w[5] = 16'h0000; w[8] = 16'h0000;
        ex = w; ex[5] = 16'h0000;
        send(w, 10, 1, 8, 0, 32'h0000_0000, 5, ex, 0, 0, "R6 zero old csum");
        w = fill(9); w[5] = 16'hFFFF; w[8] = 16'hFFFF;
        ex = w; ex[5] = 16'hFFFF; ex[8] = 16'h0000;
        send(w, 10, 1, 8, 0, 32'h0000_0000, 5, ex, 0, 0, "R6 all zero terms");
        idle(2);

        // R8: configuration changes after the first beat are ignored
        pkt(fill(10), 12, 1, 7, 1, 32'hFACE_CAFE, 3, 0, 1, "R8 cfg sampled once");
        idle(1);
        pkt(fill(11), 8, 0, 2, 0, 32'h0000_5555, 4, 0, 1, "R8 non-IP held");

        // R9: back-to-back, new packet field at word 0 while old checksum in line
        pkt(fill(12), 4, 1, 1, 0, 32'h0000_0BAD, 3, 0, 0, "R9 first pkt");
        pkt(fill(13), 6, 1, 0, 0, 32'h0000_7777, 3, 0, 0, "R9 second pkt");
        pkt(fill(14), 5, 1, 0, 1, 32'h0102_0304, 4, 0, 0, "R9 third pkt");
        idle(2);

        // R1: idle beats inside the packet keep per-beat latency
        pkt(fill(15), 9, 1, 6, 0, 32'h0000_9999, 2, 1, 0, "R1 gapped");
        pkt(fill(16), 6, 1, 4, 0, 32'h0000_0042, 1, 2, 0, "R1 R5 gapped");
        idle(3);

        // R11: byte order agnostic
        w = fill(17); nv = 32'hA1B2_C3D4;
        ex = model(w, 1, 3, 1, nv, 7);
        for (int i = 0; i < MAXW; i++) begin
            ws[i] = bswap(w[i]);
            ex[i] = bswap(ex[i]);
        end
        send(ws, 10, 1, 3, 1, {bswap(nv[31:16]), bswap(nv[15:0])}, 7, ex, 0, 0, "R11 swapped");

        idle(DEPTH + 4);
        summary();
        $finish;
    end

endmodule